// File: doc/BRIEF.md
# External Interrupt Entry Sequencer

This block carries out the state changes a processor core makes when it accepts a request from an external interrupt controller. The controller supplies four things with each request: a handler address, a requested register set, an interrupt level and a non-maskable flag. When the core asserts the take strobe, the block reads the current status word and the program counter. It then forms the new status word and decides where the old status and the return address are saved. It also presents the handler address as the next program counter.

The old status goes to the exception-status register when the request targets register set 0. For any other set it goes to that shadow set's saved-status slot. A flag in the saved copy records that the register set changed. The return address is the program counter advanced by one instruction (4 bytes). It is written to the exception-return slot of the requested set.

None of these saves happen while the exception-handling bit of the old status is set. Register-file storage lives outside the block, so the block drives only write strobes, set indices and data. A request for a shadow set beyond the configured count raises an error pulse and suppresses every write. All outputs are registered and appear one cycle after the take strobe.

Top module: `eic_entry`

## Requirements
- R1: Status bit layout: bit 0 interrupt enable, bit 1 user mode, bit 2 exception-handling (EH), bit 3 interrupt-handler (IH), bits 9:4 level, bits 15:10 current set, bits 21:16 previous set, bit 22 non-maskable, bit 23 register-set interrupt enable, bit 31 set-switched. In the new status, the current-set field equals the requested set, the level field equals the requested level, and bit 22 equals the requested non-maskable flag.
- R2: In the new status, bits 1 and 23 are clear, bit 3 is set, and bits 0, 2, 24 to 31 keep their old values.
- R3: When old EH is 0, the previous-set field takes the old current-set field. When old EH is 1, the previous-set field keeps its old value.
- R4: When old EH is 0 and the requested set is 0, the old status is written unchanged to the exception-status register, and there is no saved-status write.
- R5: When old EH is 0 and the requested set is nonzero, the old status is written to that set's saved-status slot, with bit 31 forced to 1 if the requested set differs from the old current set. There is no exception-status write.
- R6: When old EH is 0, the program counter plus 4 is written to the exception-return slot of the requested set. When old EH is 1, none of the status or return-address saves happens.
- R7: The next-PC strobe pulses with the handler address, and the status write strobe pulses with the new status, for each accepted request.
- R8: A requested set greater than NUM_SHADOW pulses the error output and produces no write of any kind and no next-PC strobe.
- R9: After reset, every strobe and the error output are low.
- R10: Outputs are registered. They appear in the cycle after take is sampled high, and every strobe is low in a cycle that follows a cycle without take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | Accept the pending external request this cycle |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Address of the interrupted instruction |
| hnd_addr_i | input | 32 | Handler address from the controller |
| req_set_i | input | 6 | Requested register set |
| req_lvl_i | input | 6 | Requested interrupt level |
| req_nmi_i | input | 1 | Request is non-maskable |
| status_we_o | output | 1 | Status register write strobe |
| status_o | output | 32 | New status word |
| estatus_we_o | output | 1 | Exception-status write strobe |
| estatus_o | output | 32 | Exception-status write data |
| sstatus_we_o | output | 1 | Shadow saved-status write strobe |
| sstatus_set_o | output | 6 | Shadow set index for the saved-status write |
| sstatus_o | output | 32 | Saved-status write data |
| ea_we_o | output | 1 | Exception-return write strobe |
| ea_set_o | output | 6 | Register set index for the return-address write |
| ea_o | output | 32 | Return-address write data |
| npc_valid_o | output | 1 | Next-PC strobe |
| npc_o | output | 32 | Next program counter |
| set_err_o | output | 1 | Requested set out of range |

## Verification
The checker takes for granted that take_i is sampled only while rst_n is high. It also assumes that the request fields and status_i are stable for the cycle in which take_i is high, since it compares registered outputs with the values of those inputs one cycle earlier. The bench drives every input on the falling edge and holds it until the next falling edge. It sweeps all 64 requested-set codes against eight old current-set values and both EH states. Between requests it drops take_i for a cycle, so each idle cycle shows the strobes falling back to zero.

// File: rtl/eic_pkg.sv
// Package: shared widths and status-word field positions for the external
// interrupt entry sequencer. Assumes a 32-bit status word and 6-bit set
// and level fields.
package eic_pkg;
    localparam int XLEN    = 32;
    localparam int SET_W   = 6;
    localparam int LVL_W   = 6;
    localparam int PC_STEP = 4;

    localparam int B_PIE  = 0;
    localparam int B_USR  = 1;
    localparam int B_EH   = 2;
    localparam int B_IH   = 3;
    localparam int F_LVL  = 4;
    localparam int F_CUR  = 10;
    localparam int F_PRV  = 16;
    localparam int B_NMI  = 22;
    localparam int B_RSIE = 23;
    localparam int B_SWCH = 31;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [SET_W-1:0] set_t;
    typedef logic [LVL_W-1:0] lvl_t;

    // Bundle of save writes produced by the routing stage.
    typedef struct packed {
        logic  est_we;
        word_t est_data;
        logic  sst_we;
        word_t sst_data;
        logic  ea_we;
        word_t ea_data;
    } save_t;

    // Extract the current-set field of a status word.
    function automatic set_t cur_set(input word_t s);
        return s[F_CUR +: SET_W];
    endfunction
endpackage

// File: rtl/eic_status_build.sv
// Module: eic_status_build
// Forms the new status word from the old one and the request fields.
// Purely combinational. Assumes the request fields are valid whenever the
// caller uses the result.
module eic_status_build
    import eic_pkg::*;
(
    input  word_t old_status,
    input  set_t  req_set,
    input  lvl_t  req_lvl,
    input  logic  req_nmi,
    output word_t new_status
);
    // Overwrite request fields, clear user/RSIE, set IH, update previous set.
    always_comb begin
        new_status                   = old_status;
        new_status[F_CUR +: SET_W]   = req_set;
        new_status[F_LVL +: LVL_W]   = req_lvl;
        new_status[B_NMI]            = req_nmi;
        new_status[B_USR]            = 1'b0;
        new_status[B_RSIE]           = 1'b0;
        new_status[B_IH]             = 1'b1;
        if (!old_status[B_EH]) begin
            new_status[F_PRV +: SET_W] = cur_set(old_status);
        end
    end
endmodule

// File: rtl/eic_range_check.sv
// Module: eic_range_check
// Decides whether a requested set index names an existing set (0 up to
// NUM_SHADOW). When every 6-bit code is legal the check reduces to a
// constant.
module eic_range_check
    import eic_pkg::*;
#(
    parameter int NUM_SHADOW = 7
) (
    input  set_t req_set,
    output logic set_ok
);
    localparam int MAX_CODE = (1 << SET_W) - 1;

    generate
        if (NUM_SHADOW >= MAX_CODE) begin : g_all_legal
            // Every code is a real set; no comparison is needed.
            assign set_ok = 1'b1;
        end else begin : g_compare
            localparam set_t LIMIT = set_t'(NUM_SHADOW);
            // Compare against the configured shadow set count.
            assign set_ok = (req_set <= LIMIT);
        end
    endgenerate
endmodule

// File: rtl/eic_save_route.sv
// Module: eic_save_route
// Chooses where the old status and return address go. All saves are
// skipped while the exception-handling bit is set or the set is illegal.
// Purely combinational.
module eic_save_route
    import eic_pkg::*;
(
    input  word_t old_status,
    input  set_t  req_set,
    input  word_t ret_pc,
    input  logic  set_ok,
    output save_t save
);
    logic do_save;
    logic switched;

    // Saves happen only outside exception handling and for a legal set.
    assign do_save  = set_ok && !old_status[B_EH];
    assign switched = (req_set != cur_set(old_status));

    // Route the old status to estatus (set 0) or the shadow saved-status slot.
    always_comb begin
        save          = '0;
        save.ea_data  = ret_pc;
        save.est_data = old_status;
        save.sst_data = old_status;
        if (switched) begin
            save.sst_data[B_SWCH] = 1'b1;
        end
        if (do_save) begin
            save.ea_we = 1'b1;
            if (req_set == '0) begin
                save.est_we = 1'b1;
            end else begin
                save.sst_we = 1'b1;
            end
        end
    end
endmodule

// File: rtl/eic_entry.sv
// Module: eic_entry (top)
// External interrupt entry sequencer. On take_i it registers the new status,
// the old-status save, the return-address save and the next PC; all
// outputs are valid for exactly one cycle after the take. Assumes inputs
// are stable in the take cycle and that arbitration happened upstream.
module eic_entry
    import eic_pkg::*;
#(
    parameter int NUM_SHADOW = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic [31:0] status_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] hnd_addr_i,
    input  logic [5:0]  req_set_i,
    input  logic [5:0]  req_lvl_i,
    input  logic        req_nmi_i,
    output logic        status_we_o,
    output logic [31:0] status_o,
    output logic        estatus_we_o,
    output logic [31:0] estatus_o,
    output logic        sstatus_we_o,
    output logic [5:0]  sstatus_set_o,
    output logic [31:0] sstatus_o,
    output logic        ea_we_o,
    output logic [5:0]  ea_set_o,
    output logic [31:0] ea_o,
    output logic        npc_valid_o,
    output logic [31:0] npc_o,
    output logic        set_err_o
);
    word_t new_status;
    word_t ret_pc;
    logic  set_ok;
    save_t save;

    // Return address: one instruction past the interrupted one.
    assign ret_pc = pc_i + word_t'(PC_STEP);

    eic_status_build u_build (
        .old_status (status_i),
        .req_set    (req_set_i),
        .req_lvl    (req_lvl_i),
        .req_nmi    (req_nmi_i),
        .new_status (new_status)
    );

    eic_range_check #(.NUM_SHADOW(NUM_SHADOW)) u_range (
        .req_set (req_set_i),
        .set_ok  (set_ok)
    );

    eic_save_route u_route (
        .old_status (status_i),
        .req_set    (req_set_i),
        .ret_pc     (ret_pc),
        .set_ok     (set_ok),
        .save       (save)
    );

    // Strobe register: pulses only in the cycle after an accepted take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_we_o  <= 1'b0;
            estatus_we_o <= 1'b0;
            sstatus_we_o <= 1'b0;
            ea_we_o      <= 1'b0;
            npc_valid_o  <= 1'b0;
            set_err_o    <= 1'b0;
        end else begin
            status_we_o  <= take_i && set_ok;
            estatus_we_o <= take_i && save.est_we;
            sstatus_we_o <= take_i && save.sst_we;
            ea_we_o      <= take_i && save.ea_we;
            npc_valid_o  <= take_i && set_ok;
            set_err_o    <= take_i && !set_ok;
        end
    end

    // Data register: captured on every take, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o      <= '0;
            estatus_o     <= '0;
            sstatus_o     <= '0;
            sstatus_set_o <= '0;
            ea_o          <= '0;
            ea_set_o      <= '0;
            npc_o         <= '0;
        end else if (take_i) begin
            status_o      <= new_status;
            estatus_o     <= save.est_data;
            sstatus_o     <= save.sst_data;
            sstatus_set_o <= req_set_i;
            ea_o          <= save.ea_data;
            ea_set_o      <= req_set_i;
            npc_o         <= hnd_addr_i;
        end
    end
endmodule

// File: rtl/eic_entry_chk.sv
// Module: eic_entry_chk
// Checker bound to eic_entry. Relates registered outputs to the inputs of
// the take cycle.
module eic_entry_chk
    import eic_pkg::*;
#(
    parameter int NUM_SHADOW = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        take_i,
    input logic [31:0] status_i,
    input logic [31:0] pc_i,
    input logic [31:0] hnd_addr_i,
    input logic [5:0]  req_set_i,
    input logic [5:0]  req_lvl_i,
    input logic        req_nmi_i,
    input logic        status_we_o,
    input logic [31:0] status_o,
    input logic        estatus_we_o,
    input logic [31:0] estatus_o,
    input logic        sstatus_we_o,
    input logic [5:0]  sstatus_set_o,
    input logic        ea_we_o,
    input logic [31:0] ea_o,
    input logic        npc_valid_o,
    input logic [31:0] npc_o,
    input logic        set_err_o
);
    logic legal;
    assign legal = (int'(req_set_i) <= NUM_SHADOW);

    p_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && legal) |=> (status_o[F_CUR +: SET_W] == $past(req_set_i)
                               && status_o[F_LVL +: LVL_W] == $past(req_lvl_i)
                               && status_o[B_NMI] == $past(req_nmi_i)));

    p_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_we_o |-> (status_o[B_IH] && !status_o[B_USR] && !status_o[B_RSIE]));

    p_save_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({estatus_we_o, sstatus_we_o}));

    p_est_r4: assert property (@(posedge clk) disable iff (!rst_n)
        estatus_we_o |-> (estatus_o == $past(status_i)));

    p_sst_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sstatus_we_o |-> (sstatus_set_o != '0));

    p_ea_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && legal && !status_i[B_EH]) |=> (ea_we_o && ea_o == $past(pc_i) + 32'd4));

    p_eh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && status_i[B_EH]) |=> !(ea_we_o || estatus_we_o || sstatus_we_o));

    p_npc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && legal) |=> (npc_valid_o && npc_o == $past(hnd_addr_i)));

    p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_err_o |-> !(status_we_o || estatus_we_o || sstatus_we_o || ea_we_o || npc_valid_o));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> !(status_we_o || npc_valid_o || set_err_o || ea_we_o));
endmodule

bind eic_entry eic_entry_chk #(.NUM_SHADOW(NUM_SHADOW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_i        (take_i),
    .status_i      (status_i),
    .pc_i          (pc_i),
    .hnd_addr_i    (hnd_addr_i),
    .req_set_i     (req_set_i),
    .req_lvl_i     (req_lvl_i),
    .req_nmi_i     (req_nmi_i),
    .status_we_o   (status_we_o),
    .status_o      (status_o),
    .estatus_we_o  (estatus_we_o),
    .estatus_o     (estatus_o),
    .sstatus_we_o  (sstatus_we_o),
    .sstatus_set_o (sstatus_set_o),
    .ea_we_o       (ea_we_o),
    .ea_o          (ea_o),
    .npc_valid_o   (npc_valid_o),
    .npc_o         (npc_o),
    .set_err_o     (set_err_o)
);

// File: tb/sim_eic_entry.sv
module sim_eic_entry;
    localparam int CLK_PERIOD = 10;
    localparam int NSH        = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [31:0] status_i = '0, pc_i = '0, hnd_addr_i = '0;
    logic [5:0]  req_set_i = '0, req_lvl_i = '0;
    logic        req_nmi_i = 1'b0;
    logic        status_we_o, estatus_we_o, sstatus_we_o, ea_we_o, npc_valid_o, set_err_o;
    logic [31:0] status_o, estatus_o, sstatus_o, ea_o, npc_o;
    logic [5:0]  sstatus_set_o, ea_set_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eic_entry #(.NUM_SHADOW(NSH)) u0 (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .status_i(status_i),
        .pc_i(pc_i), .hnd_addr_i(hnd_addr_i), .req_set_i(req_set_i),
        .req_lvl_i(req_lvl_i), .req_nmi_i(req_nmi_i),
        .status_we_o(status_we_o), .status_o(status_o),
        .estatus_we_o(estatus_we_o), .estatus_o(estatus_o),
        .sstatus_we_o(sstatus_we_o), .sstatus_set_o(sstatus_set_o),
        .sstatus_o(sstatus_o), .ea_we_o(ea_we_o), .ea_set_o(ea_set_o),
        .ea_o(ea_o), .npc_valid_o(npc_valid_o), .npc_o(npc_o),
        .set_err_o(set_err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected new status from the R1..R3 bit layout.
    function automatic logic [31:0] exp_status(input logic [31:0] s, input logic [5:0] rs,
                                               input logic [5:0] il, input logic nmi);
        logic [31:0] n = s;
        n[15:10] = rs;
        n[9:4]   = il;
        n[22]    = nmi;
        n[1]     = 1'b0;
        n[23]    = 1'b0;
        n[3]     = 1'b1;
        if (!s[2]) n[21:16] = s[15:10];
        return n;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({status_we_o, estatus_we_o, sstatus_we_o, ea_we_o, npc_valid_o, set_err_o} == 6'b0,
            "R9 reset strobes", 64'({status_we_o, estatus_we_o, sstatus_we_o, ea_we_o, npc_valid_o, set_err_o}), 64'h0);
        rst_n = 1'b1;
        for (int rs = 0; rs < 64; rs++) begin
            for (int oc = 0; oc < 8; oc++) begin
                for (int eh = 0; eh < 2; eh++) begin
                    int v = rs * 16 + oc * 2 + eh;
                    logic [31:0] s, ns, es, ss;
                    logic err, ewe, swe, awe;
                    s = 32'(v) * 32'h9E37_79B9 ^ 32'h5A5A_C3C3;
                    s[15:10] = 6'(oc);
                    s[2] = eh[0];
                    @(negedge clk);
                    status_i   = s;
                    pc_i       = 32'h1000_0000 + 32'(v) * 32'd4;
                    hnd_addr_i = 32'h8000_0000 ^ (32'(v) << 4);
                    req_set_i  = 6'(rs);
                    req_lvl_i  = 6'(v * 5);
                    req_nmi_i  = v[3];
                    take_i     = 1'b1;
                    @(negedge clk);
                    take_i = 1'b0;
                    err = (rs > NSH);
                    ns  = exp_status(s, 6'(rs), 6'(v * 5), v[3]);
                    ewe = !err && !eh[0] && rs == 0;
                    swe = !err && !eh[0] && rs != 0;
                    awe = !err && !eh[0];
                    ss  = s;
                    if (rs != oc) ss[31] = 1'b1;
                    es  = s;
                    // R8: error pulse
                    chk(set_err_o == err, "R8 err", 64'(set_err_o), 64'(err));
                    // R7: status/npc strobes and data
                    chk(status_we_o == !err && npc_valid_o == !err, "R7 strobes",
                        64'({status_we_o, npc_valid_o}), 64'({!err, !err}));
                    if (!err) begin
                        // R1, R2, R3: new status content
                        chk(status_o == ns, "R1 R2 R3 status", 64'(status_o), 64'(ns));
                        chk(npc_o == hnd_addr_i, "R7 npc", 64'(npc_o), 64'(hnd_addr_i));
                    end
                    // R4: estatus write
                    chk(estatus_we_o == ewe, "R4 est_we", 64'(estatus_we_o), 64'(ewe));
                    if (ewe) chk(estatus_o == es, "R4 est data", 64'(estatus_o), 64'(es));
                    // R5: saved-status write
                    chk(sstatus_we_o == swe, "R5 sst_we", 64'(sstatus_we_o), 64'(swe));
                    if (swe) chk(sstatus_o == ss && sstatus_set_o == 6'(rs), "R5 sst data",
                                 {26'(sstatus_set_o), sstatus_o}, {26'(rs), ss});
                    // R6: return-address write
                    chk(ea_we_o == awe, "R6 ea_we", 64'(ea_we_o), 64'(awe));
                    if (awe) chk(ea_o == pc_i + 32'd4 && ea_set_o == 6'(rs), "R6 ea data",
                                 {26'(ea_set_o), ea_o}, {26'(rs), pc_i + 32'd4});
                    @(negedge clk);
                    // R10: idle cycle leaves strobes low
                    chk({status_we_o, estatus_we_o, sstatus_we_o, ea_we_o, npc_valid_o, set_err_o} == 6'b0,
                        "R10 idle", 64'({status_we_o, estatus_we_o, sstatus_we_o, ea_we_o, npc_valid_o, set_err_o}), 64'h0);
                end
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule